// File: doc/BRIEF.md
# Multi-Group Serial Interrupt Aggregator

This block gathers the interrupt-pending lines of up to four groups of eight serial channels and reduces them to a single host interrupt line. The reduction happens in two levels. Each group keeps a registered byte that shows which of its channels are interrupting. A controller summary then shows which groups have at least one such channel. Software reads both levels through a small byte-wide register port. It can mask single channels, take whole groups out of service, gate delivery to the host and acknowledge with an end-of-interrupt strobe.

A second source of interrupts is a periodic tick. It comes from the system clock through a divider, at one of six rates that halve from the fastest (about 274 Hz) down to about 9 Hz. A mode bit can limit the host line to these ticks alone. The host line is a registered level. An acknowledge pulls it low for one cycle, so that an edge-sensitive host sees a fresh edge when work is still pending.

Top module: `sirq_aggregator`

## Requirements
- R1: Group status register (address 4+g) bit i equals channel line i of group g ANDed with mask bit i. The bit is registered, so it follows the line one clock later. It reads as zero while the group's enable bit (config bits 3:0, bit g) is clear.
- R2: Controller summary (address 2) holds, in bit g, the OR of group g's status byte. Bits 7:4 always read 0.
- R3: Extended summary (address 3) holds the same group flags in bits 3:0 and the tick-pending flag in bit 4. Bits 7:5 read 0. The tick-pending flag sets on a tick and stays set until a strobe clears it.
- R4: The rate code is config bits 6:4. For codes 1..6 the tick period is BASE<<(6-code) clock cycles, where BASE = CLK_HZ/TOP_RATE_HZ. Codes 0 and 7 produce no ticks.
- R5: Any change of the rate code restarts the divider. The first tick after the change makes the pending flag readable P+1 cycles after the write edge, where P is the new period. Later ticks follow every P cycles.
- R6: The host line is a register that is high when the enable bit (address 0, bit 3) is set and an allowed source is pending. With the enable bit clear, the line is low one cycle later.
- R7: With the tick-only bit (config bit 7) set, pending groups do not drive the host line. Only the tick-pending flag does.
- R8: Writing address 0 with bit 2 set is a strobe. It forces the host line low on the next edge and clears tick-pending. If a source is still pending, the line returns high on the edge after that.
- R9: A cleared mask bit (address 8+g, reset 0xFF) removes that channel from its group status byte, from the summaries and from the host line.
- R10: Address 0 reads back the enable bit only (the strobe bit reads 0). Address 1 reads back as written. At reset all registers are 0, except the masks, which are 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_irq | input | 32 | Channel pending lines, group g in bits 8g+7:8g |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational from rd_addr) |
| host_irq | output | 1 | Host interrupt line |

## Verification
On every cycle the assertions check several things. Disabled groups and masked channels never show in a group byte. No tick fires while the rate code is off or has just changed. A strobe always drops the host line on the next edge. The line stays low while delivery is disabled, and in tick-only mode it stays low while no tick is pending. The exact tick periods for each rate code, the restart of the divider on a rate change, the re-assertion of the line after an acknowledge and the register readback can only be shown by the bench's timed scenarios.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int REG_W       = 8;
    localparam int ADDR_W      = 4;
    localparam int CHANS       = 8;
    localparam int MAX_GROUPS  = 4;
    localparam int RATE_W      = 3;
    localparam int FASTEST     = 6;

    localparam logic [ADDR_W-1:0] A_HOSTCTL = 4'h0;
    localparam logic [ADDR_W-1:0] A_CFG     = 4'h1;
    localparam logic [ADDR_W-1:0] A_GSUM    = 4'h2;
    localparam logic [ADDR_W-1:0] A_XSUM    = 4'h3;
    localparam logic [ADDR_W-1:0] A_GSTAT0  = 4'h4;
    localparam logic [ADDR_W-1:0] A_MASK0   = 4'h8;

    localparam int BIT_HOST_EN = 3;
    localparam int BIT_STROBE  = 2;
    localparam int BIT_TONLY   = 7;

    // Period in clock cycles for a rate code; zero means no ticks.
    function automatic int unsigned tick_period(input logic [RATE_W-1:0] code,
                                                input int unsigned base);
        if (code >= 3'd1 && code <= 3'(FASTEST))
            return base << (FASTEST - int'(code));
        return 0;
    endfunction
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
    import sirq_pkg::*;
#(
    parameter int NUM_GROUPS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [REG_W-1:0]                  wr_data,
    output logic                              host_en,
    output logic                              tick_only,
    output logic [RATE_W-1:0]                 rate,
    output logic [NUM_GROUPS-1:0]             grp_en,
    output logic [NUM_GROUPS-1:0][CHANS-1:0]  mask,
    output logic                              strobe
);
    typedef struct packed {
        logic                             host_en;
        logic                             tick_only;
        logic [RATE_W-1:0]                rate;
        logic [NUM_GROUPS-1:0]            grp_en;
        logic [NUM_GROUPS-1:0][CHANS-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        strobe = wr_en && (wr_addr == A_HOSTCTL) && wr_data[BIT_STROBE];
        if (wr_en) begin
            if (wr_addr == A_HOSTCTL) begin
                r_d.host_en = wr_data[BIT_HOST_EN];
            end
            if (wr_addr == A_CFG) begin
                r_d.tick_only = wr_data[BIT_TONLY];
                r_d.rate      = wr_data[6:4];
                r_d.grp_en    = wr_data[NUM_GROUPS-1:0];
            end
            for (int g = 0; g < NUM_GROUPS; g++) begin
                if (wr_addr == A_MASK0 + ADDR_W'(g))
                    r_d.mask[g] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.host_en   <= 1'b0;
            r_q.tick_only <= 1'b0;
            r_q.rate      <= '0;
            r_q.grp_en    <= '0;
            r_q.mask      <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_en   = r_q.host_en;
    assign tick_only = r_q.tick_only;
    assign rate      = r_q.rate;
    assign grp_en    = r_q.grp_en;
    assign mask      = r_q.mask;

    // R10: a write to the control address with bit 3 set leaves delivery enabled
    a_r10_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_HOSTCTL && wr_data[BIT_HOST_EN]) |=> host_en);
endmodule

// File: rtl/sirq_group.sv
module sirq_group
    import sirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CHANS-1:0] mask_i,
    input  logic [CHANS-1:0] chan_i,
    output logic [CHANS-1:0] stat_o,
    output logic             flag_o
);
    typedef struct packed {
        logic [CHANS-1:0] stat;
    } grp_t;

    grp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.stat = en_i ? (chan_i & mask_i) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;
    assign flag_o = |s_q.stat;

    // R1: a disabled group shows no pending channel on the next cycle
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (stat_o == '0));
    // R9: masked channels never reach the status byte
    a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(mask_i)) == '0));
endmodule

// File: rtl/sirq_tick.sv
module sirq_tick
    import sirq_pkg::*;
#(
    parameter int unsigned BASE_DIV = 20,
    parameter int          CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [RATE_W-1:0] prev;
    } tick_t;

    tick_t       s_d, s_q;
    int unsigned period;
    logic        changed;
    logic        active;

    always_comb begin
        s_d     = s_q;
        period  = tick_period(rate_i, BASE_DIV);
        active  = (period != 0);
        changed = (rate_i != s_q.prev);
        tick_o  = active && !changed && (s_q.cnt == CNT_W'(period - 1));
        s_d.prev = rate_i;
        if (changed || !active || tick_o) s_d.cnt = '0;
        else                              s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: codes 0 and 7 never tick
    a_r4_off_codes_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == 3'd0 || rate_i == 3'd7) |-> !tick_o);
    // R5: the cycle after a rate change never ticks
    a_r5_restart_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i != $past(rate_i)) |-> !tick_o);
endmodule

// File: rtl/sirq_host.sv
module sirq_host (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_only_i,
    input  logic grp_any_i,
    input  logic tick_i,
    input  logic strobe_i,
    output logic irq_o,
    output logic tick_pend_o
);
    typedef struct packed {
        logic irq;
        logic tick_pend;
    } host_t;

    host_t s_d, s_q;
    logic  src;

    always_comb begin
        s_d           = s_q;
        src           = tick_only_i ? s_q.tick_pend : (grp_any_i | s_q.tick_pend);
        s_d.tick_pend = tick_i | (s_q.tick_pend & ~strobe_i);
        s_d.irq       = en_i & src & ~strobe_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o       = s_q.irq;
    assign tick_pend_o = s_q.tick_pend;

    // R8: an acknowledge always drops the line on the next edge
    a_r8_strobe_drops: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> !irq_o);
    // R6: with delivery disabled the line is low next cycle
    a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);
    // R7: in tick-only mode groups alone cannot raise the line
    a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_only_i && !tick_pend_o) |=> !irq_o);
    // R3: pending flag only rises after a tick
    a_r3_pend_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_pend_o) |-> $past(tick_i));
endmodule

// File: rtl/sirq_aggregator.sv
module sirq_aggregator
    import sirq_pkg::*;
#(
    parameter int          NUM_GROUPS  = 4,
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned TOP_RATE_HZ = 274
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS*CHANS-1:0] chan_irq,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [REG_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [REG_W-1:0]            rd_data,
    output logic                        host_irq
);
    localparam int unsigned BASE_DIV = CLK_HZ / TOP_RATE_HZ;
    localparam int unsigned MAX_PER  = BASE_DIV << (FASTEST - 1);
    localparam int          CNT_W    = $clog2(MAX_PER + 1);

    logic                             host_en, tick_only, strobe, tick, tick_pend;
    logic [RATE_W-1:0]                rate;
    logic [NUM_GROUPS-1:0]            grp_en, grp_flag;
    logic [NUM_GROUPS-1:0][CHANS-1:0] mask, gstat;
    logic [MAX_GROUPS-1:0]            flags4, en4;

    sirq_regs #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .host_en(host_en), .tick_only(tick_only),
        .rate(rate), .grp_en(grp_en), .mask(mask), .strobe(strobe)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        sirq_group u_grp (
            .clk(clk), .rst_n(rst_n), .en_i(grp_en[g]), .mask_i(mask[g]),
            .chan_i(chan_irq[g*CHANS +: CHANS]), .stat_o(gstat[g]),
            .flag_o(grp_flag[g])
        );
    end

    sirq_tick #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .rate_i(rate), .tick_o(tick)
    );

    sirq_host u_host (
        .clk(clk), .rst_n(rst_n), .en_i(host_en), .tick_only_i(tick_only),
        .grp_any_i(|grp_flag), .tick_i(tick), .strobe_i(strobe),
        .irq_o(host_irq), .tick_pend_o(tick_pend)
    );

    always_comb begin
        flags4 = '0;
        en4    = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            flags4[g] = grp_flag[g];
            en4[g]    = grp_en[g];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_HOSTCTL: rd_data[BIT_HOST_EN] = host_en;
            A_CFG:     rd_data = {tick_only, rate, en4};
            A_GSUM:    rd_data = {4'b0, flags4};
            A_XSUM:    rd_data = {3'b0, tick_pend, flags4};
            default: begin
                for (int g = 0; g < NUM_GROUPS; g++) begin
                    if (rd_addr == A_GSTAT0 + ADDR_W'(g)) rd_data = gstat[g];
                    if (rd_addr == A_MASK0 + ADDR_W'(g))  rd_data = mask[g];
                end
            end
        endcase
    end

    // R2: the summary upper nibble is always clear
    a_r2_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_GSUM) |-> (rd_data[7:4] == 4'b0));
endmodule

// File: tb/tb_sirq_aggregator.sv
module tb_sirq_aggregator;
    import sirq_pkg::*;

    localparam int NG = 4;
    localparam int BASE = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*8-1:0]   chan_irq = '0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [3:0]        rd_addr = '0;
    logic [7:0]        rd_data;
    logic              host_irq;

    int checks = 0, fails = 0, cyc = 0, issued = 0, mon_done = 0;
    logic [7:0] peek_val;

    typedef struct {
        int         kind;   // 0 register check, 1 line check, 2 peek
        logic [3:0] addr;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    sirq_aggregator #(.NUM_GROUPS(NG), .CLK_HZ(274 * BASE), .TOP_RATE_HZ(274)) dut (
        .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .host_irq(host_irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    // Monitor: pops expected items and compares them with the outputs
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.kind == 1) begin
                checks++;
                if (host_irq !== it.exp[0]) begin
                    fails++;
                    $display("FAIL %s host_irq actual=%b expected=%b", it.req, host_irq, it.exp[0]);
                end
            end else begin
                rd_addr = it.addr;
                #1;
                if (it.kind == 0) begin
                    checks++;
                    if (rd_data !== it.exp) begin
                        fails++;
                        $display("FAIL %s addr %0h actual=%02h expected=%02h", it.req, it.addr, rd_data, it.exp);
                    end
                end else begin
                    peek_val = rd_data;
                end
            end
            mon_done++;
        end
    end

    task automatic push(input int kind, input logic [3:0] a, input logic [7:0] e, input string r);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.req = r;
        sb.push_back(it);
        issued++;
        wait (mon_done == issued);
    endtask

    task automatic chk_reg(input logic [3:0] a, input logic [7:0] e, input string r);
        push(0, a, e, r);
    endtask
    task automatic chk_irq(input logic e, input string r);
        push(1, 4'h0, {7'b0, e}, r);
    endtask
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask
    task automatic chk_num(input int act, input int exp, input string r);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s interval actual=%0d expected=%0d", r, act, exp);
        end
    endtask
    // Returns the cycle count at which tick-pending is first seen
    task automatic wait_pend(output int k);
        k = -1;
        for (int i = 0; i < 3000; i++) begin
            push(2, A_XSUM, 8'h00, "peek");
            if (peek_val[4]) begin
                k = cyc;
                break;
            end
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        int k0, k1, k2;
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state
        chk_irq(1'b0, "R6 reset");
        chk_reg(A_GSUM, 8'h00, "R2 reset");
        chk_reg(A_XSUM, 8'h00, "R3 reset");
        chk_reg(A_CFG, 8'h00, "R10 reset cfg");
        chk_reg(A_MASK0, 8'hFF, "R10 reset mask");

        // Groups enabled, delivery still off
        wr(A_CFG, 8'h0F);
        chan_irq = (32'h1 << 3) | (32'h1 << 23);
        step(2);
        chk_reg(4'h4, 8'h08, "R1 group0 status");
        chk_reg(4'h6, 8'h80, "R1 group2 status");
        chk_reg(A_GSUM, 8'h05, "R2 summary");
        chk_irq(1'b0, "R6 gated off");

        wr(A_HOSTCTL, 8'h08);
        step(1);
        chk_irq(1'b1, "R6 enabled line");
        chk_reg(A_HOSTCTL, 8'h08, "R10 control readback");

        // Mask channel 3 of group 0
        wr(4'h8, 8'hF7);
        step(1);
        chk_reg(4'h4, 8'h00, "R9 masked channel");
        chk_reg(A_GSUM, 8'h04, "R9 summary after mask");
        chk_reg(4'h8, 8'hF7, "R10 mask readback");

        // Take group 2 out of service
        wr(A_CFG, 8'h0B);
        step(1);
        chk_reg(4'h6, 8'h00, "R1 disabled group");
        step(1);
        chk_irq(1'b0, "R9 no unmasked source");
        wr(A_CFG, 8'h0F);
        step(2);
        chk_irq(1'b1, "R6 source restored");

        // Acknowledge while still pending
        wr(A_HOSTCTL, 8'h0C);
        chk_irq(1'b0, "R8 strobe drops line");
        step(1);
        chk_irq(1'b1, "R8 line reasserts");
        chk_reg(A_HOSTCTL, 8'h08, "R10 strobe bit reads 0");

        wr(A_HOSTCTL, 8'h00);
        step(1);
        chk_irq(1'b0, "R6 disable drops line");

        // Tick-only with rate off: groups ignored
        wr(A_HOSTCTL, 8'h08);
        wr(A_CFG, 8'h8F);
        step(2);
        chk_irq(1'b0, "R7 groups ignored");
        chk_reg(A_XSUM, 8'h04, "R3 ext summary no tick");

        // Fastest rate: period BASE
        wr(A_CFG, 8'hEF);
        k0 = cyc;
        wait_pend(k1);
        chk_num(k1 - k0, BASE + 1, "R5 first tick code6");
        step(1);
        chk_irq(1'b1, "R7 tick raises line");
        chk_reg(A_XSUM, 8'h14, "R3 pending bit4");
        wr(A_HOSTCTL, 8'h0C);
        chk_irq(1'b0, "R8 strobe drops tick line");
        chk_reg(A_XSUM, 8'h04, "R8 pending cleared");
        wait_pend(k2);
        chk_num(k2 - k1, BASE, "R4 period code6");

        // Code 5 restart
        wr(A_CFG, 8'hDF);
        k0 = cyc;
        wr(A_HOSTCTL, 8'h0C);
        wait_pend(k1);
        chk_num(k1 - k0, 2 * BASE + 1, "R4 first tick code5");
        wr(A_HOSTCTL, 8'h0C);
        wait_pend(k2);
        chk_num(k2 - k1, 2 * BASE, "R4 period code5");

        // Mid-count change from code 6 to code 4
        wr(A_CFG, 8'hEF);
        wr(A_HOSTCTL, 8'h0C);
        step(10);
        wr(A_CFG, 8'hCF);
        k0 = cyc;
        wr(A_HOSTCTL, 8'h0C);
        wait_pend(k1);
        chk_num(k1 - k0, 4 * BASE + 1, "R5 restart on change");

        // Code 1, slowest
        wr(A_CFG, 8'h9F);
        k0 = cyc;
        wr(A_HOSTCTL, 8'h0C);
        wait_pend(k1);
        chk_num(k1 - k0, 32 * BASE + 1, "R4 first tick code1");

        // Codes 0 and 7 stay silent
        wr(A_CFG, 8'h8F);
        wr(A_HOSTCTL, 8'h0C);
        step(700);
        chk_reg(A_XSUM, 8'h04, "R4 code0 silent");
        wr(A_CFG, 8'hFF);
        chk_reg(A_CFG, 8'hFF, "R10 cfg readback");
        step(200);
        chk_reg(A_XSUM, 8'h04, "R4 code7 silent");
        chk_irq(1'b0, "R7 no tick no line");

        // Leave tick-only mode, drop channels
        wr(A_CFG, 8'h0F);
        step(2);
        chk_irq(1'b1, "R6 group source again");
        chan_irq = '0;
        step(2);
        chk_reg(A_GSUM, 8'h00, "R2 all quiet");
        chk_irq(1'b0, "R6 no source");

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule